// File: doc/BRIEF.md
# Interrupt Vector Snoop Interceptor

This block listens passively on a processor expansion bus and, once armed by a button press, takes over exactly one vector fetch. It never requests an interrupt itself. It waits for the processor to service an interrupt or a reset on its own accord. That event shows up on the bus as two back-to-back reads in the top eight bytes of the address space. The block lets the first read (the low byte) pass. During the second read (the high byte) it raises an override strobe and presents a replacement byte. The external bus logic uses that byte to steer the vector toward other code.

One bus cycle equals one period of the bus clock `phi2`. The external reset goes through a clock-domain synchronizer before it acts, so the block settles into its reset state on the second `phi2` edge after reset goes low. After it intercepts a fetch, the block drops its armed state and raises a frozen flag. It cannot be armed again until that flag has been cleared and the button pressed again. The replacement byte is held in a small register that can be loaded through a strobe.

Top module: `vec_snoop_intercept`

## Requirements
- R1: While `rst_n` is held low, `armed` is still unchanged after the first `phi2` rising edge and is cleared by the second; after `rst_n` rises the block leaves reset after two further edges.
- R2: While not armed, vector-area reads never assert `ovr_en`, however many arrive in a row.
- R3: A rising edge of `arm_btn` sampled on a clock edge sets `armed` at that edge, provided `frozen` is low.
- R4: While armed, the second of two consecutive reads (`bus_rd_wn`=1) with addresses in 0xFFF8..0xFFFF asserts `ovr_en` combinationally during that second cycle only, and the first read does not.
- R5: A read at an address outside 0xFFF8..0xFFFF (0xFFF7 included) between two vector-area reads restarts the pair, so the next vector read counts as a first one.
- R6: A write cycle (`bus_rd_wn`=0), even to 0xFFF8..0xFFFF, restarts the pair in the same way.
- R7: The edge that ends an intercepted cycle clears `armed` and sets `frozen`; while `frozen` is high, button presses leave `armed` low.
- R8: A `frz_clr` pulse clears `frozen`, and a later button press arms the block again.
- R9: `ovr_data` equals the replacement register while `ovr_en` is high and is 0x00 otherwise; the register resets to 0xA5 and takes `cfg_byte` on a clock edge where `cfg_ld` is high.
- R10: Reset clears `armed`, `frozen`, the pair progress and `ovr_en`; a single vector read after re-arming does not trigger an override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi2 | input | 1 | Bus clock, one period per bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized internally |
| bus_addr | input | 16 | Address of the current bus cycle |
| bus_rd_wn | input | 1 | 1 = read cycle, 0 = write cycle |
| arm_btn | input | 1 | Debounced arm button level, active high |
| frz_clr | input | 1 | Clears the frozen flag |
| cfg_ld | input | 1 | Load strobe for the replacement byte |
| cfg_byte | input | 8 | New replacement byte value |
| ovr_en | output | 1 | Override strobe, high during the intercepted cycle |
| ovr_data | output | 8 | Replacement byte, zero when not overriding |
| armed | output | 1 | Detection armed |
| frozen | output | 1 | An interception has happened and has not been cleared |

## Verification
The assertions check on every cycle that the override lasts a single cycle, that it only comes after a vector read in the previous cycle and alongside one in the current cycle, that it never occurs unarmed or right after a broken pair, and that it is always followed by disarm and freeze. They also check that arming only follows a button press made while not frozen. Only the directed scenarios can show the two-edge reset latency, the 0xFFF7 and 0xFFFF boundaries, the replacement byte values, and that pair progress is lost across reset.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int VEC_LSB = 3;

  // True when the address falls inside the top (1 << VEC_LSB) bytes.
  function automatic logic in_vec_area(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:VEC_LSB];
  endfunction

  // Next value of the pair progress counter.
  function automatic logic [3:0] pair_next(input logic [3:0] cnt, input logic hit,
                                           input logic fire);
    if (!hit || fire) return 4'd0;
    return cnt + 4'd1;
  endfunction
endpackage

// File: rtl/vsi_rst_sync.sv
module vsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[0] <= rst_in_n;
      end else begin : g_rest
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rst_out_n = chain[STAGES-1];
endmodule

// File: rtl/vsi_arm_ctrl.sv
module vsi_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic btn,
  input  logic clr,
  input  logic fire,
  output logic armed,
  output logic frozen
);
  logic btn_q;
  logic btn_rise;

  assign btn_rise = btn && !btn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_q  <= 1'b0;
      armed  <= 1'b0;
      frozen <= 1'b0;
    end else begin
      btn_q <= btn;
      if (fire) begin
        armed  <= 1'b0;
        frozen <= 1'b1;
      end else begin
        if (clr) frozen <= 1'b0;
        if (btn_rise && !frozen) armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vsi_vec_detect.sv
module vsi_vec_detect
  import vsi_pkg::*;
#(
  parameter int PAIR_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_wn,
  output logic              vec_hit,
  output logic              fire
);
  localparam logic [3:0] LAST = 4'(PAIR_LEN - 1);

  logic [3:0] cnt;

  assign vec_hit = rd_wn && in_vec_area(addr);
  assign fire    = armed && vec_hit && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= 4'd0;
    else if (!armed) cnt <= 4'd0;
    else             cnt <= pair_next(cnt, vec_hit, fire);
  end
endmodule

// File: rtl/vsi_repl_reg.sv
module vsi_repl_reg #(
  parameter int          W     = 8,
  parameter logic [W-1:0] RESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RESET;
    else if (ld) q <= din;
  end
endmodule

// File: rtl/vec_snoop_intercept.sv
module vec_snoop_intercept
  import vsi_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          PAIR_LEN    = 2,
  parameter logic [7:0]  DEF_REPL    = 8'hA5
) (
  input  logic        phi2,
  input  logic        rst_n,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd_wn,
  input  logic        arm_btn,
  input  logic        frz_clr,
  input  logic        cfg_ld,
  input  logic [7:0]  cfg_byte,
  output logic        ovr_en,
  output logic [7:0]  ovr_data,
  output logic        armed,
  output logic        frozen
);
  logic       core_rst_n;
  logic       vec_hit;
  logic       fire;
  logic [7:0] repl_q;

  vsi_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(phi2), .rst_in_n(rst_n), .rst_out_n(core_rst_n)
  );

  vsi_arm_ctrl u_arm (
    .clk(phi2), .rst_n(core_rst_n), .btn(arm_btn), .clr(frz_clr),
    .fire(fire), .armed(armed), .frozen(frozen)
  );

  vsi_vec_detect #(.PAIR_LEN(PAIR_LEN)) u_det (
    .clk(phi2), .rst_n(core_rst_n), .armed(armed), .addr(bus_addr),
    .rd_wn(bus_rd_wn), .vec_hit(vec_hit), .fire(fire)
  );

  vsi_repl_reg #(.W(DATA_W), .RESET(DEF_REPL)) u_repl (
    .clk(phi2), .rst_n(core_rst_n), .ld(cfg_ld), .din(cfg_byte), .q(repl_q)
  );

  assign ovr_en   = fire && core_rst_n;
  assign ovr_data = ovr_en ? repl_q : 8'h00;
endmodule

// File: rtl/vsi_checker.sv
module vsi_checker (
  input logic clk,
  input logic rst_n,
  input logic core_rst_n,
  input logic arm_btn,
  input logic armed,
  input logic frozen,
  input logic vec_hit,
  input logic ovr
);
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    ovr |=> !ovr);
  a_r4_after_vec_read: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    ovr |-> (vec_hit && $past(vec_hit)));
  a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    !armed |-> !ovr);
  a_r5_break_restarts: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    !vec_hit |=> !ovr);
  a_r7_freeze_follows: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    ovr |=> (frozen && !armed));
  a_r3_arm_cause: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    $rose(armed) |-> ($past(arm_btn) && !$past(frozen)));
endmodule

bind vec_snoop_intercept vsi_checker u_chk (
  .clk(phi2), .rst_n(rst_n), .core_rst_n(core_rst_n), .arm_btn(arm_btn),
  .armed(armed), .frozen(frozen), .vec_hit(vec_hit), .ovr(ovr_en)
);

// File: tb/vec_snoop_intercept_tb.sv
module vec_snoop_intercept_tb;
  logic        phi2 = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h1000;
  logic        bus_rd_wn = 1'b1;
  logic        arm_btn = 1'b0;
  logic        frz_clr = 1'b0;
  logic        cfg_ld = 1'b0;
  logic [7:0]  cfg_byte = 8'h00;
  logic        ovr_en;
  logic [7:0]  ovr_data;
  logic        armed;
  logic        frozen;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic       s_ovr;
  logic [7:0] s_data;

  always #2 phi2 = ~phi2;

  vec_snoop_intercept u_dut (
    .phi2(phi2), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_wn(bus_rd_wn),
    .arm_btn(arm_btn), .frz_clr(frz_clr), .cfg_ld(cfg_ld), .cfg_byte(cfg_byte),
    .ovr_en(ovr_en), .ovr_data(ovr_data), .armed(armed), .frozen(frozen)
  );

  function automatic bit vec_range(input logic [15:0] a);
    return a >= 16'hFFF8;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, sample before the rising edge.
  task automatic cyc(input logic [15:0] a, input logic rd, input logic btn = 1'b0,
                     input logic clr = 1'b0);
    @(negedge phi2);
    bus_addr = a; bus_rd_wn = rd; arm_btn = btn; frz_clr = clr;
    #1;
    s_ovr = ovr_en;
    s_data = ovr_data;
  endtask

  task automatic idle(); cyc(16'h1000, 1'b1); endtask
  task automatic press(); cyc(16'h1000, 1'b1, 1'b1); idle(); endtask
  task automatic unfreeze(); cyc(16'h1000, 1'b1, 1'b0, 1'b1); endtask

  task automatic t_reset();
    repeat (4) idle();
    rst_n = 1'b1;
    repeat (3) idle();
    chk("R10 armed after reset", armed, 0);
    chk("R10 frozen after reset", frozen, 0);
    chk("R10 ovr after reset", s_ovr, 0);
    chk("R9 data idle zero", s_data, 8'h00);
  endtask

  task automatic t_unarmed();
    cyc(16'hFFFE, 1'b1); chk("R2 unarmed first", s_ovr, 0);
    cyc(16'hFFFF, 1'b1); chk("R2 unarmed second", s_ovr, 0);
    cyc(16'hFFFC, 1'b1); chk("R2 unarmed third", s_ovr, 0);
  endtask

  task automatic t_intercept();
    press();
    chk("R3 armed by press", armed, 1);
    cyc(16'hFFFA, 1'b1); chk("R4 first read passes", s_ovr, 0);
    cyc(16'hFFFB, 1'b1);
    chk("R4 second read taken", s_ovr, 1);
    chk("R9 default byte", s_data, 8'hA5);
    cyc(16'hFFFA, 1'b1);
    chk("R4 one cycle only", s_ovr, 0);
    chk("R7 disarmed", armed, 0);
    chk("R7 frozen set", frozen, 1);
    cyc(16'hFFFB, 1'b1); chk("R7 no repeat", s_ovr, 0);
  endtask

  task automatic t_frozen_ignore();
    press();
    chk("R7 press ignored while frozen", armed, 0);
  endtask

  task automatic t_rearm();
    unfreeze(); idle();
    chk("R8 frozen cleared", frozen, 0);
    press();
    chk("R8 re-armed", armed, 1);
  endtask

  task automatic t_break();
    cyc(16'hFFFC, 1'b1); chk("R5 vec read", s_ovr, 0);
    cyc(16'h4000, 1'b1); chk("R5 gap read", s_ovr, 0);
    cyc(16'hFFFD, 1'b1); chk("R5 restarted", s_ovr, 0);
    cyc(16'hFFF7, 1'b1); chk("R5 below range", s_ovr, 0);
    cyc(16'hFFF8, 1'b1); chk("R5 low edge first", s_ovr, 0);
    cyc(16'hFFFF, 1'b1);
    chk("R5 high edge second", s_ovr, int'(vec_range(16'hFFFF) && vec_range(16'hFFF8)));
    idle();
    unfreeze(); press();
  endtask

  task automatic t_write();
    @(negedge phi2); cfg_ld = 1'b1; cfg_byte = 8'h3C;
    @(negedge phi2); cfg_ld = 1'b0;
    cyc(16'hFFFE, 1'b1); chk("R6 vec read", s_ovr, 0);
    cyc(16'hFFFF, 1'b0); chk("R6 write not taken", s_ovr, 0);
    cyc(16'hFFFE, 1'b1); chk("R6 restarted", s_ovr, 0);
    cyc(16'hFFFF, 1'b1);
    chk("R6 pair after write", s_ovr, 1);
    chk("R9 loaded byte", s_data, 8'h3C);
    idle();
    unfreeze(); press();
  endtask

  task automatic t_reset_mid();
    cyc(16'hFFFA, 1'b1);
    @(negedge phi2); rst_n = 1'b0; bus_addr = 16'h1000;
    #1; chk("R1 before edges", armed, 1);
    idle(); chk("R1 one edge", armed, 1);
    idle(); chk("R1 two edges", armed, 0);
    rst_n = 1'b1;
    repeat (3) idle();
    chk("R10 frozen cleared", frozen, 0);
    press();
    cyc(16'hFFFB, 1'b1); chk("R10 count cleared", s_ovr, 0);
    cyc(16'hFFFA, 1'b1);
    chk("R10 fresh pair", s_ovr, 1);
    chk("R9 default restored", s_data, 8'hA5);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unarmed();
    t_intercept();
    t_frozen_ignore();
    t_rearm();
    t_break();
    t_write();
    t_reset_mid();
    idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule